// File: doc/BRIEF.md
# MSI Write Device-ID Tagging Bridge

This bridge sits on the write path between a bus master and the doorbell register of an interrupt translation service. Each incoming 32-bit write request is sorted into one of three cases. The first case is a write into a dedicated alias window. Such a write is redirected to the single doorbell address, and the device identifier is taken from the word offset of the write inside the window. The second case is a write that targets the doorbell address itself; it is forwarded tagged with identifier zero. The third case is any other write, which passes through unchanged and is marked as not being an interrupt message.

The window spans `4 << DEVID_BITS` bytes and its base address is aligned to that size. Window membership is therefore one equality test on the upper address bits. Inside the window, a write that is not word aligned or that does not enable all four bytes is discarded. Each discarded write raises a one-cycle error pulse. The output is a single registered stage with a valid/ready handshake, and requests leave in the order they arrived.

Top module: `msi_tag_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `err_pulse` are 0 after that edge.
- R2: An accepted write with an address inside the window, address bits [1:0] equal to 0 and `in_strb` equal to 4'b1111 appears on the output one edge later. Its address is `DOORBELL_ADDR`, its data is unchanged, `out_strb` is 4'b1111, `out_devid` is address bits [DEVID_BITS+1:2] of the write, and `out_not_msi` is 0.
- R3: The window covers `WIN_BASE` up to `WIN_BASE + (4 << DEVID_BITS) - 1`. With the defaults, the word at `WIN_BASE + 0x1FFFFC` is remapped with device ID 0x7FFFF. The words at `WIN_BASE - 4` and `WIN_BASE + 0x200000` are treated as ordinary writes.
- R4: An accepted write whose address equals `DOORBELL_ADDR` is forwarded with its address, data and strobes unchanged, `out_devid` 0 and `out_not_msi` 0.
- R5: An accepted write outside the window and not at `DOORBELL_ADDR` is forwarded with its address, data and strobes unchanged, `out_devid` 0 and `out_not_msi` 1.
- R6: An accepted window write whose address bits [1:0] are not 0, or whose `in_strb` is not 4'b1111, produces no output request. `err_pulse` is 1 for exactly the one cycle that follows the accepting edge. `err_pulse` is 0 after any edge that accepts no such write.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and the output request holds its value until it is taken.
- R8: Requests leave in arrival order, without loss or duplication. When `out_ready` is held high, one request is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming write request is present |
| in_ready | output | 1 | Bridge takes the request on this edge |
| in_addr | input | ADDR_W | Byte address of the incoming write |
| in_data | input | DATA_W | Write data |
| in_strb | input | DATA_W/8 | Byte enables |
| out_valid | output | 1 | Output request is present |
| out_ready | input | 1 | Downstream takes the output request |
| out_addr | output | ADDR_W | Output byte address |
| out_data | output | DATA_W | Output write data |
| out_strb | output | DATA_W/8 | Output byte enables |
| out_devid | output | DEVID_BITS | Device identifier tag |
| out_not_msi | output | 1 | 1 when the write is not an interrupt message |
| err_pulse | output | 1 | One-cycle pulse for each discarded window write |

## Verification
Two events can fall on the same clock edge. The downstream can take the request held in the output stage while a new write is accepted behind it. A discarded window write can also be accepted on the very edge on which the previous output leaves. Both cases are provoked in directed sequences and by long streams of mixed writes, with `out_ready` toggled pseudo-randomly. On every accepting edge, a scoreboard queue checks that each output appears once and in order, and that the error pulse appears or stays low as the kind of write demands.

// File: rtl/msi_tag_pkg.sv
// Package msi_tag_pkg
// Shared types for the device-ID tagging bridge.
// Assumes nothing beyond a standard SystemVerilog tool flow.
package msi_tag_pkg;

    // Kind of an incoming write once its address and strobes have been decoded.
    typedef enum logic [1:0] {
        WR_PASS     = 2'd0,  // ordinary write, forwarded untouched
        WR_DOORBELL = 2'd1,  // direct doorbell write, tag 0
        WR_ALIAS    = 2'd2,  // valid alias-window write, remapped
        WR_REJECT   = 2'd3   // malformed alias-window write, dropped
    } wr_kind_e;

endpackage

// File: rtl/msi_addr_classifier.sv
// Module msi_addr_classifier
// Purely combinational decode of one write request. It returns the kind of
// the write and the device tag carried by the window offset.
// Assumes WIN_BASE is aligned to the window size of 4 << DEVID_BITS bytes,
// so that membership is one compare on the bits above the offset.
// The window test has priority over the doorbell test.
module msi_addr_classifier
    import msi_tag_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                STRB_W        = 4,
    parameter int                DEVID_BITS    = 19,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h5800_0000,
    parameter logic [ADDR_W-1:0] DOORBELL_ADDR = 32'h3003_0040
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [STRB_W-1:0]     strb,
    output wr_kind_e              kind,
    output logic [DEVID_BITS-1:0] devid
);
    // Lowest address bit that lies above the window offset.
    localparam int WIN_LSB = DEVID_BITS + 2;

    logic win_hit;
    logic word_ok;
    logic full_ok;

    // Window membership: the upper address bits must equal the base.
    assign win_hit = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    // Well-formed alias access: word aligned with all bytes enabled.
    assign word_ok = (addr[1:0] == 2'b00);
    assign full_ok = &strb;

    // Sort the write into its kind and extract the tag of an alias write.
    always_comb begin
        kind  = WR_PASS;
        devid = '0;
        if (win_hit) begin
            if (word_ok && full_ok) begin
                kind  = WR_ALIAS;
                devid = addr[WIN_LSB-1:2];
            end else begin
                kind  = WR_REJECT;
            end
        end else if (addr == DOORBELL_ADDR) begin
            kind = WR_DOORBELL;
        end
    end

endmodule

// File: rtl/msi_out_stage.sv
// Module msi_out_stage
// Single-entry registered output stage with a valid/ready handshake, plus
// the registered error pulse for dropped writes.
// Assumes load and drop are only asserted on an accepted request and are
// never both high. in_ready stays high while the stage is empty or being
// emptied, so arrival order is kept and throughput is one request per cycle.
module msi_out_stage #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int STRB_W     = 4,
    parameter int DEVID_BITS = 19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  drop,
    input  logic [ADDR_W-1:0]     nxt_addr,
    input  logic [DATA_W-1:0]     nxt_data,
    input  logic [STRB_W-1:0]     nxt_strb,
    input  logic [DEVID_BITS-1:0] nxt_devid,
    input  logic                  nxt_not_msi,
    output logic                  in_ready,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ADDR_W-1:0]     out_addr,
    output logic [DATA_W-1:0]     out_data,
    output logic [STRB_W-1:0]     out_strb,
    output logic [DEVID_BITS-1:0] out_devid,
    output logic                  out_not_msi,
    output logic                  err_pulse
);
    // Upstream may proceed when the stage is empty or is emptied this cycle.
    assign in_ready = !out_valid || out_ready;

    // Occupancy flag: fill on load, clear when taken without a refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Payload capture: only written on load, so it holds while stalled.
    always_ff @(posedge clk) begin
        if (load) begin
            out_addr    <= nxt_addr;
            out_data    <= nxt_data;
            out_strb    <= nxt_strb;
            out_devid   <= nxt_devid;
            out_not_msi <= nxt_not_msi;
        end
    end

    // Error pulse: high for the cycle after each dropped request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= drop;
        end
    end

endmodule

// File: rtl/msi_tag_bridge.sv
// Module msi_tag_bridge
// Write-path bridge that tags interrupt doorbell writes with a device ID.
// Alias-window writes are redirected to DOORBELL_ADDR with the tag taken from
// the word offset. Direct doorbell writes get tag 0. Other writes pass with
// the not-MSI flag set. Malformed window writes are dropped and flagged.
// Assumes DATA_W is 32, WIN_BASE is aligned to 4 << DEVID_BITS, and
// DOORBELL_ADDR lies outside the window.
module msi_tag_bridge
    import msi_tag_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                DATA_W        = 32,
    parameter int                DEVID_BITS    = 19,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h5800_0000,
    parameter logic [ADDR_W-1:0] DOORBELL_ADDR = 32'h3003_0040
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [DATA_W-1:0]       in_data,
    input  logic [DATA_W/8-1:0]     in_strb,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [DATA_W-1:0]       out_data,
    output logic [DATA_W/8-1:0]     out_strb,
    output logic [DEVID_BITS-1:0]   out_devid,
    output logic                    out_not_msi,
    output logic                    err_pulse
);
    localparam int STRB_W = DATA_W / 8;

    wr_kind_e              kind;
    logic [DEVID_BITS-1:0] tag;
    logic                  accept;
    logic                  load;
    logic                  drop;
    logic [ADDR_W-1:0]     nxt_addr;
    logic [STRB_W-1:0]     nxt_strb;
    logic                  nxt_not_msi;

    // Address and strobe decode of the incoming request.
    msi_addr_classifier #(
        .ADDR_W        (ADDR_W),
        .STRB_W        (STRB_W),
        .DEVID_BITS    (DEVID_BITS),
        .WIN_BASE      (WIN_BASE),
        .DOORBELL_ADDR (DOORBELL_ADDR)
    ) u_classify (
        .addr  (in_addr),
        .strb  (in_strb),
        .kind  (kind),
        .devid (tag)
    );

    // Handshake qualification: forward or drop only accepted requests.
    assign accept = in_valid && in_ready;
    assign load   = accept && (kind != WR_REJECT);
    assign drop   = accept && (kind == WR_REJECT);

    // Rewrite of the request fields by kind.
    always_comb begin
        nxt_addr    = in_addr;
        nxt_strb    = in_strb;
        nxt_not_msi = 1'b0;
        unique case (kind)
            WR_ALIAS: begin
                nxt_addr = DOORBELL_ADDR;
                nxt_strb = '1;
            end
            WR_PASS:     nxt_not_msi = 1'b1;
            WR_DOORBELL: nxt_not_msi = 1'b0;
            WR_REJECT:   nxt_not_msi = 1'b0;
            default:     nxt_not_msi = 1'b0;
        endcase
    end

    // Registered output stage and error pulse.
    msi_out_stage #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STRB_W     (STRB_W),
        .DEVID_BITS (DEVID_BITS)
    ) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .drop        (drop),
        .nxt_addr    (nxt_addr),
        .nxt_data    (in_data),
        .nxt_strb    (nxt_strb),
        .nxt_devid   (tag),
        .nxt_not_msi (nxt_not_msi),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_addr    (out_addr),
        .out_data    (out_data),
        .out_strb    (out_strb),
        .out_devid   (out_devid),
        .out_not_msi (out_not_msi),
        .err_pulse   (err_pulse)
    );

endmodule

// File: rtl/msi_tag_bridge_chk.sv
// Module msi_tag_bridge_chk
// Property checker for msi_tag_bridge, attached through the bind below.
// It watches only the ports of the bridge.
module msi_tag_bridge_chk #(
    parameter int                ADDR_W        = 32,
    parameter int                DATA_W        = 32,
    parameter int                DEVID_BITS    = 19,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h5800_0000,
    parameter logic [ADDR_W-1:0] DOORBELL_ADDR = 32'h3003_0040
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [ADDR_W-1:0]     in_addr,
    input logic [DATA_W/8-1:0]   in_strb,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [ADDR_W-1:0]     out_addr,
    input logic [DATA_W-1:0]     out_data,
    input logic [DATA_W/8-1:0]   out_strb,
    input logic [DEVID_BITS-1:0] out_devid,
    input logic                  out_not_msi,
    input logic                  err_pulse
);
    localparam int WIN_LSB = DEVID_BITS + 2;

    logic take;
    logic in_win;
    logic win_good;

    // Observer-side decode of the request on the input port.
    assign take     = in_valid && in_ready;
    assign in_win   = (in_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    assign win_good = in_win && (in_addr[1:0] == 2'b00) && (&in_strb);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !err_pulse));

    assert_alias_remap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_good) |=> (out_valid && !out_not_msi &&
            (out_addr == DOORBELL_ADDR) && (&out_strb) &&
            (out_devid == $past(in_addr[WIN_LSB-1:2]))));

    assert_msi_at_doorbell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_not_msi) |-> (out_addr == DOORBELL_ADDR));

    assert_plain_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_win && (in_addr != DOORBELL_ADDR)) |=>
            (out_valid && out_not_msi && (out_devid == '0) &&
             (out_addr == $past(in_addr))));

    assert_bad_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_win && !win_good) |=> err_pulse);

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(take));

    assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
            $stable(out_data) && $stable(out_devid) && $stable(out_not_msi)));

endmodule

bind msi_tag_bridge msi_tag_bridge_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .DEVID_BITS    (DEVID_BITS),
    .WIN_BASE      (WIN_BASE),
    .DOORBELL_ADDR (DOORBELL_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_addr     (in_addr),
    .in_strb     (in_strb),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_data    (out_data),
    .out_strb    (out_strb),
    .out_devid   (out_devid),
    .out_not_msi (out_not_msi),
    .err_pulse   (err_pulse)
);

// File: tb/msi_tag_bridge_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for msi_tag_bridge: a driver pushes expected outputs, a
// monitor pops them at every output handshake.
module msi_tag_bridge_bench;
    localparam int          AW   = 32;
    localparam int          DW   = 32;
    localparam int          NB   = 19;
    localparam logic [31:0] BASE = 32'h5800_0000;
    localparam logic [31:0] WSZ  = 32'h0020_0000;
    localparam logic [31:0] DB   = 32'h3003_0040;

    typedef struct packed {
        logic [31:0]   addr;
        logic [31:0]   data;
        logic [3:0]    strb;
        logic [NB-1:0] devid;
        logic          not_msi;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_addr = '0;
    logic [31:0]   in_data = '0;
    logic [3:0]    in_strb = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [31:0]   out_addr;
    logic [31:0]   out_data;
    logic [3:0]    out_strb;
    logic [NB-1:0] out_devid;
    logic          out_not_msi;
    logic          err_pulse;

    int    n_vec = 0;
    int    n_bad = 0;
    int    rdy_mode = 0;
    int    n_drop_exp = 0;
    int    n_err_seen = 0;
    bit    done = 0;
    item_t q_exp[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    msi_tag_bridge #(
        .ADDR_W(AW), .DATA_W(DW), .DEVID_BITS(NB),
        .WIN_BASE(BASE), .DOORBELL_ADDR(DB)
    ) u_msi_tag_bridge (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_strb(in_strb),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data), .out_strb(out_strb),
        .out_devid(out_devid), .out_not_msi(out_not_msi),
        .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected result of one write, derived from the requirements.
    task automatic model(input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] s, output bit drop, output item_t it,
                         output string tag);
        bit win;
        logic [31:0] off;
        win  = (a >= BASE) && (a < BASE + WSZ);
        off  = a - BASE;
        drop = 0;
        it   = '{addr: a, data: d, strb: s, devid: '0, not_msi: 1'b0};
        if (win) begin
            if (a[1:0] != 2'b00 || s != 4'hF) begin
                drop = 1;
                tag  = "R6";
            end else begin
                it.addr  = DB;
                it.strb  = 4'hF;
                it.devid = off[NB+1:2];
                tag      = "R2/R3";
            end
        end else if (a == DB) begin
            tag = "R4";
        end else begin
            it.not_msi = 1'b1;
            tag        = "R5";
        end
    endtask

    // Driver: present one write, wait for acceptance, check the error pulse.
    task automatic send(input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s);
        bit    drop;
        item_t it;
        string tag;
        model(a, d, s, drop, it, tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_data  = d;
        in_strb  = s;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        if (drop) n_drop_exp++;
        else begin
            q_exp.push_back(it);
            q_tag.push_back(tag);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check(err_pulse == drop, "R6", "err_pulse after accept",
              128'(err_pulse), 128'(drop));
    endtask

    // Downstream ready pattern, updated away from the active edge.
    always @(negedge clk) begin
        if (rdy_mode == 0) out_ready = 1'b1;
        else if (rdy_mode == 2) out_ready = 1'b0;
        else out_ready = ($urandom % 3) != 0;
    end

    // Monitor: compare each output handshake with the head of the queue.
    always @(negedge clk) begin
        #2;
        if (rst_n && err_pulse) n_err_seen++;
        if (rst_n && out_valid && out_ready) begin
            if (q_exp.size() == 0) begin
                check(0, "R8", "unexpected output", 128'(out_addr), 128'(0));
            end else begin
                item_t e;
                item_t g;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                g = '{addr: out_addr, data: out_data, strb: out_strb,
                      devid: out_devid, not_msi: out_not_msi};
                check(g == e, t, "output request", 128'(g), 128'(e));
            end
        end
    end

    initial begin
        logic [31:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        #2;
        check(!out_valid && !err_pulse, "R1", "during reset",
              128'({out_valid, err_pulse}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!out_valid && !err_pulse && in_ready, "R1", "after reset",
              128'({out_valid, err_pulse, in_ready}), 128'(1));

        // R2: alias window remap
        send(BASE + 32'h0, 32'hA5A5_0001, 4'hF);
        send(BASE + 32'h1_234C, 32'hA5A5_0002, 4'hF);
        // R3: window edges
        send(BASE + 32'h1F_FFFC, 32'hA5A5_0003, 4'hF);
        send(BASE - 32'h4, 32'hA5A5_0004, 4'hF);
        send(BASE + WSZ, 32'hA5A5_0005, 4'hF);
        // R4: direct doorbell
        send(DB, 32'hA5A5_0006, 4'hF);
        send(DB, 32'hA5A5_0007, 4'h3);
        // R5: ordinary write
        send(32'h1000_0000, 32'hA5A5_0008, 4'h5);
        // R6: malformed window writes, then an alias write right behind
        send(BASE + 32'h102, 32'hA5A5_0009, 4'hF);
        send(BASE + 32'h100, 32'hA5A5_000A, 4'h7);
        send(BASE + 32'h100, 32'hA5A5_000B, 4'hF);

        // R7: stall holds the output and blocks the input
        repeat (2) @(negedge clk);
        rdy_mode = 2;
        send(BASE + 32'h40, 32'hBEEF_0001, 4'hF);
        @(negedge clk);
        #2;
        held = out_addr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #2;
            check(out_valid && !in_ready && out_addr == held, "R7",
                  "stalled output", 128'({out_valid, in_ready, out_addr}),
                  128'({1'b1, 1'b0, held}));
        end
        fork
            send(32'h2000_0010, 32'hBEEF_0002, 4'hF);
            begin
                repeat (3) @(negedge clk);
                rdy_mode = 0;
            end
        join

        // R8: mixed traffic with random backpressure
        rdy_mode = 1;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [31:0] a;
            logic [3:0]  s;
            r = $urandom;
            s = 4'hF;
            case (r[1:0])
                2'd0: a = BASE + (r & 32'h001F_FFFC);
                2'd1: a = DB;
                2'd2: begin a = $urandom; s = r[7:4]; end
                default: begin a = BASE + (r & 32'h001F_FFFF); s = r[11:8]; end
            endcase
            send(a, $urandom, s);
        end
        rdy_mode = 0;
        repeat (6) @(negedge clk);
        check(q_exp.size() == 0, "R8", "all outputs delivered",
              128'(q_exp.size()), 128'(0));
        check(n_err_seen == n_drop_exp, "R6", "error pulse count",
              128'(n_err_seen), 128'(n_drop_exp));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(100000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R8 watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule